// File: doc/BRIEF.md
# Link Error Severity Classifier and Reporter

This block watches nine single-cycle error event lines from a serial link controller and sorts each event into one of three severity classes: correctable, non-fatal uncorrectable and fatal. Every event type has its own saturating occurrence counter. Every class has a sticky status bit that software clears by writing a one to it.

When an event arrives in a class whose reporting enable is set, the block raises a one-cycle request for an error message toward the upstream port. The request carries a class code. When events of several classes arrive in the same cycle, the code names the most severe class that is both detected and enabled. Any fatal event also raises a one-cycle request to reset the downstream link, whatever the enables say.

Building the message packet and acting on the reset request belong to neighbouring logic. An asynchronous active-low reset clears all state. Its release passes through a two-flop synchronizer.

Top module: `ecls_top`

## Requirements
- R1: Event line k (bits 0..8 of `err_i`) increments only counter k, at `cnt_o[4k+3:4k]`, one cycle after the pulse. A counter whose line is idle holds its value.
- R2: Event lines 0..2 (bad transaction packet, bad link packet, replay timer expiry) set status bit 0. Lines 3..5 (completion timeout, unexpected completion, access violation) set status bit 1. Lines 6..8 (flow control protocol error, malformed packet, end-to-end CRC failure) set status bit 2. Each bit is set one cycle after the pulse.
- R3: A status bit stays set until software writes a one to it.
- R4: A write with `clr_wr_i` high clears every status bit whose `clr_data_i` bit is 1 and leaves the other bits alone. If a new event of a class arrives in the same cycle as the clear, the new event wins and the bit stays set.
- R5: Each counter stops at 15 (all ones) and never wraps.
- R6: `msg_req_o` pulses one cycle after an event only when `rpt_en_i` has the bit of that event's class set. `msg_class_o` is 0 for correctable, 1 for non-fatal and 2 for fatal, and reads 0 whenever `msg_req_o` is low.
- R7: When several classes arrive in one cycle, `msg_class_o` names the most severe class that is both detected and enabled.
- R8: `link_rst_o` pulses one cycle after any fatal event, regardless of `rpt_en_i`. Correctable and non-fatal events never raise it.
- R9: While reset is asserted, all status bits, counters and request outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | 9 | Single-cycle event pulses, one per error type |
| rpt_en_i | input | 3 | Reporting enable per class (bit 0 correctable, 1 non-fatal, 2 fatal) |
| clr_wr_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 3 | Write-one-to-clear mask for the status bits |
| status_o | output | 3 | Sticky class status bits |
| cnt_o | output | 36 | Nine 4-bit saturating counters, type k at bits 4k+3..4k |
| msg_req_o | output | 1 | Error message request toward the upstream port |
| msg_class_o | output | 2 | Class of the requested message |
| link_rst_o | output | 1 | Downstream link reset request |

## Verification
Every result of this block is registered once, so status, counters, message request, message class and link reset are all due exactly one clock after the event or clear write that causes them. The bench changes inputs on the falling edge and clears the event lines again on the next falling edge. It compares all outputs at that second falling edge, so the one intervening rising edge is the only one that can have acted on the stimulus. After reset is released, the bench idles for several cycles so the two-flop synchronizer has let go before any event is applied.

// File: rtl/ecls_pkg.sv
`timescale 1ns/1ps
package ecls_pkg;

  localparam int N_ERR   = 9;
  localparam int N_CLASS = 3;
  localparam int PER_CLS = N_ERR / N_CLASS;

  typedef enum logic [1:0] {
    SEV_CORR     = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  // Event lines are grouped by class in ascending severity.
  function automatic logic [N_ERR-1:0] class_mask(input int cls);
    logic [N_ERR-1:0] m;
    m = '0;
    for (int i = 0; i < N_ERR; i++) begin
      if ((i / PER_CLS) == cls) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecls_classify.sv
`timescale 1ns/1ps
module ecls_classify
  import ecls_pkg::*;
(
  input  logic [N_ERR-1:0]   err,
  output logic [N_CLASS-1:0] hit
);

  for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
    localparam logic [N_ERR-1:0] MASK = class_mask(c);
    assign hit[c] = |(err & MASK);
  end

endmodule

// File: rtl/ecls_counter.sv
`timescale 1ns/1ps
module ecls_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic         at_max;
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    at_max = &cnt;
    cnt_en = inc & ~at_max;
    cnt_d  = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/ecls_status.sv
`timescale 1ns/1ps
module ecls_status
  import ecls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] hit,
  input  logic               clr_wr,
  input  logic [N_CLASS-1:0] clr_data,
  output logic [N_CLASS-1:0] status
);

  logic [N_CLASS-1:0] clr_mask;
  logic [N_CLASS-1:0] status_d;
  logic               status_en;

  always_comb begin
    clr_mask  = clr_wr ? clr_data : '0;
    status_d  = (status & ~clr_mask) | hit;
    status_en = clr_wr | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (status_en) begin
      status <= status_d;
    end
  end

endmodule

// File: rtl/ecls_report.sv
`timescale 1ns/1ps
module ecls_report
  import ecls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] hit,
  input  logic [N_CLASS-1:0] rpt_en,
  output logic               msg_req,
  output sev_e               msg_class,
  output logic               link_rst
);

  logic [N_CLASS-1:0] act;
  logic               req_d;
  sev_e               cls_d;
  logic               rst_d;

  always_comb begin
    act   = hit & rpt_en;
    req_d = |act;
    rst_d = hit[SEV_FATAL];
    if (act[SEV_FATAL]) begin
      cls_d = SEV_FATAL;
    end else if (act[SEV_NONFATAL]) begin
      cls_d = SEV_NONFATAL;
    end else begin
      cls_d = SEV_CORR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_req   <= 1'b0;
      msg_class <= SEV_CORR;
      link_rst  <= 1'b0;
    end else begin
      msg_req   <= req_d;
      msg_class <= cls_d;
      link_rst  <= rst_d;
    end
  end

endmodule

// File: rtl/ecls_top.sv
`timescale 1ns/1ps
module ecls_top
  import ecls_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8:0]             err_i,
  input  logic [2:0]             rpt_en_i,
  input  logic                   clr_wr_i,
  input  logic [2:0]             clr_data_i,
  output logic [2:0]             status_o,
  output logic [9*CNT_W-1:0]     cnt_o,
  output logic                   msg_req_o,
  output logic [1:0]             msg_class_o,
  output logic                   link_rst_o
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [N_CLASS-1:0] hit;
  sev_e               cls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  ecls_classify u_classify (
    .err (err_i),
    .hit (hit)
  );

  for (genvar k = 0; k < N_ERR; k++) begin : g_cnt
    ecls_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (err_i[k]),
      .cnt   (cnt_o[k*CNT_W +: CNT_W])
    );
  end

  ecls_status u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .clr_wr   (clr_wr_i),
    .clr_data (clr_data_i),
    .status   (status_o)
  );

  ecls_report u_report (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit       (hit),
    .rpt_en    (rpt_en_i),
    .msg_req   (msg_req_o),
    .msg_class (cls_q),
    .link_rst  (link_rst_o)
  );

  assign msg_class_o = cls_q;

endmodule

// File: rtl/ecls_chk.sv
`timescale 1ns/1ps
module ecls_chk #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [8:0]         err_i,
  input logic [2:0]         rpt_en_i,
  input logic               clr_wr_i,
  input logic [2:0]         clr_data_i,
  input logic [2:0]         status_o,
  input logic [9*CNT_W-1:0] cnt_o,
  input logic               msg_req_o,
  input logic [1:0]         msg_class_o,
  input logic               link_rst_o
);

  localparam logic [CNT_W-1:0] MAX = '1;

  logic [2:0] keep;
  logic [2:0] seen;
  assign keep = status_o & ~(clr_wr_i ? clr_data_i : 3'b000);
  assign seen = {|err_i[8:6], |err_i[5:3], |err_i[2:0]};

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_o & $past(keep)) == $past(keep)));  // R3
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_o & $past(seen)) == $past(seen)));  // R2
  AST_FATAL_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen[2] |=> link_rst_o);  // R8
  AST_NO_SPURIOUS_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seen[2] |=> !link_rst_o);  // R8
  AST_MSG_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|(seen & rpt_en_i)) |=> !msg_req_o);  // R6
  AST_FATAL_CLASS_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_req_o && msg_class_o == 2'd2) |-> link_rst_o);  // R7
  AST_IDLE_CLASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !msg_req_o |-> (msg_class_o == 2'd0));  // R6

  for (genvar k = 0; k < 9; k++) begin : g_cnt_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cnt_o[k*CNT_W +: CNT_W] == MAX) |=> (cnt_o[k*CNT_W +: CNT_W] == MAX));  // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !err_i[k] |=> $stable(cnt_o[k*CNT_W +: CNT_W]));  // R1
  end

endmodule

bind ecls_top ecls_chk #(.CNT_W(CNT_W)) i_ecls_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .err_i       (err_i),
  .rpt_en_i    (rpt_en_i),
  .clr_wr_i    (clr_wr_i),
  .clr_data_i  (clr_data_i),
  .status_o    (status_o),
  .cnt_o       (cnt_o),
  .msg_req_o   (msg_req_o),
  .msg_class_o (msg_class_o),
  .link_rst_o  (link_rst_o)
);

// File: tb/test_ecls_top.sv
`timescale 1ns/1ps
module test_ecls_top;

  localparam int CW = 4;
  localparam int CMAX = 15;

  // {err[8:0], en[2:0], msg, cls[1:0], rst}
  localparam logic [15:0] TBL [12] = '{
    16'b000000001_111_1_00_0,
    16'b000000010_000_0_00_0,
    16'b000001000_010_1_01_0,
    16'b000100000_001_0_00_0,
    16'b001000000_100_1_10_1,
    16'b010000000_000_0_00_1,
    16'b100000101_111_1_10_1,
    16'b000010100_111_1_01_0,
    16'b100010001_011_1_01_1,
    16'b000000100_001_1_00_0,
    16'b111111111_101_1_10_1,
    16'b000000000_111_0_00_0
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [8:0]     err_i;
  logic [2:0]     rpt_en_i;
  logic           clr_wr_i;
  logic [2:0]     clr_data_i;
  logic [2:0]     status_o;
  logic [9*CW-1:0] cnt_o;
  logic           msg_req_o;
  logic [1:0]     msg_class_o;
  logic           link_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt [9];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecls_top #(.CNT_W(CW)) i_ecls_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_i       (err_i),
    .rpt_en_i    (rpt_en_i),
    .clr_wr_i    (clr_wr_i),
    .clr_data_i  (clr_data_i),
    .status_o    (status_o),
    .cnt_o       (cnt_o),
    .msg_req_o   (msg_req_o),
    .msg_class_o (msg_class_o),
    .link_rst_o  (link_rst_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Entered and left at a falling edge; outputs sampled one rising edge later.
  task automatic apply(input logic [8:0] e, input logic [2:0] en);
    err_i    = e;
    rpt_en_i = en;
    for (int i = 0; i < 9; i++) begin
      if (e[i] && mcnt[i] < CMAX) mcnt[i]++;
    end
    @(negedge clk);
    err_i = '0;
  endtask

  task automatic clear(input logic [2:0] d, input logic [8:0] e);
    clr_wr_i   = 1'b1;
    clr_data_i = d;
    err_i      = e;
    for (int i = 0; i < 9; i++) begin
      if (e[i] && mcnt[i] < CMAX) mcnt[i]++;
    end
    @(negedge clk);
    clr_wr_i = 1'b0;
    err_i    = '0;
  endtask

  task automatic chk_counters(input string req);
    for (int i = 0; i < 9; i++) begin
      chk(req, int'(cnt_o[i*CW +: CW]), mcnt[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; err_i = '0; rpt_en_i = '0; clr_wr_i = 1'b0; clr_data_i = '0;
    for (int i = 0; i < 9; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 status", int'(status_o), 0);
    chk("R9 counters", int'(|cnt_o), 0);
    chk("R9 msg_req", int'(msg_req_o), 0);
    chk("R9 link_rst", int'(link_rst_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 R7 R8 vector walk
    for (int v = 0; v < 12; v++) begin
      apply(TBL[v][15:7], TBL[v][6:4]);
      chk($sformatf("R6 msg_req v%0d", v), int'(msg_req_o), int'(TBL[v][3]));
      chk($sformatf("R7 msg_class v%0d", v), int'(msg_class_o), int'(TBL[v][2:1]));
      chk($sformatf("R8 link_rst v%0d", v), int'(link_rst_o), int'(TBL[v][0]));
    end
    chk_counters("R1 counters after walk");
    chk("R2 status all classes", int'(status_o), 7);

    // R4 full clear
    clear(3'b111, 9'b0);
    chk("R4 clear all", int'(status_o), 0);
    // R2 per-class setting
    apply(9'b000000010, 3'b000);
    chk("R2 correctable -> bit0", int'(status_o), 1);
    chk("R6 disabled no msg", int'(msg_req_o), 0);
    chk("R8 correctable no reset", int'(link_rst_o), 0);
    apply(9'b000010000, 3'b000);
    chk("R3 bit0 sticky with nonfatal", int'(status_o), 3);
    repeat (3) @(negedge clk);
    chk("R3 held while idle", int'(status_o), 3);
    // R4 partial clear
    clear(3'b010, 9'b0);
    chk("R4 clear bit1 only", int'(status_o), 1);
    clear(3'b000, 9'b0);
    chk("R4 zero write no effect", int'(status_o), 1);
    clear(3'b001, 9'b000000100);
    chk("R4 new event beats clear", int'(status_o), 1);
    apply(9'b010000000, 3'b000);
    chk("R2 fatal -> bit2", int'(status_o), 5);
    chk("R8 fatal reset with reporting off", int'(link_rst_o), 1);

    // R5 saturation on type 3
    for (int n = 0; n < 20; n++) apply(9'b000001000, 3'b000);
    chk("R5 saturate at 15", int'(cnt_o[3*CW +: CW]), CMAX);
    chk_counters("R1 other counters untouched");
    repeat (2) @(negedge clk);
    chk("R5 no wrap", int'(cnt_o[3*CW +: CW]), CMAX);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule